// File: doc/BRIEF.md
# Fast Ethernet PCS Receive Decoder

This block sits behind clock and data recovery on a 100 Mb/s copper or fiber link. It takes one recovered line bit per enabled clock and undoes the physical coding in stages. First the NRZI line level is turned back into NRZ. In copper mode the NRZ bits are then descrambled. Next, 5-bit code groups are located and each one is mapped back to a 4-bit nibble. The nibbles leave on an MII-style receive interface: a nibble strobe, a data-valid level, an error flag and the nibble itself.

The local descrambler has no seed in common with the far-end scrambler. It synchronizes itself on the idle stream, which carries all-ones plaintext, so every received bit there reveals one keystream bit. Code-group boundaries are taken from the start-of-stream pair /J/K/. Once the boundaries are known, a strobe is produced every five received bits. In fiber mode the descrambler is bypassed and no lock is needed.

Top module: `fe_pcs_rx`

## Requirements
- R1: While rst_ni is low and directly after it rises, nib_en_o, rx_dv_o, rx_er_o and lock_o are 0.
- R2: A line bit is taken only in a cycle with bit_en_i high. The NRZ value is 1 when the line level differs from the previous sampled level and 0 when it matches. The line level before the first bit counts as 0.
- R3: In copper mode (fiber_i=0) the keystream is k = s[n-11] xor s[n-9] and plaintext = received NRZ xor k. Before lock, the state is loaded with the inverted received bit. lock_o rises after LOCK_RUN consecutive bits that decode to 1 under the current state. It cannot rise after fewer than LOCK_RUN idle bits.
- R4: While locked, ZERO_LIMIT consecutive plaintext zeros (default 4) clear lock_o. No legal code-group stream contains more than 3 zeros in a row.
- R5: Code-group alignment is set only by the 10-bit pattern 11000 10001, earliest bit first. The first data group is the next five bits. Groups of valid data codes received without this pattern produce no nibble with rx_dv_o=1.
- R6: nib_en_o pulses once per five received bits after alignment. For an in-frame data group it shows rx_dv_o=1, rx_er_o=0 and rxd_o equal to the standard 4B/5B nibble, e.g. 11110→0, 01001→1, 11101→F.
- R7: An in-frame group 01101 (/T/) ends the frame. The strobe for that group shows rx_dv_o=0, rx_er_o=0, and no further dv nibble follows.
- R8: Any in-frame group that is not data, /T/ or idle gives a strobe with rx_dv_o=1, rx_er_o=1, rxd_o=0, and the frame continues.
- R9: An in-frame idle group 11111 gives a strobe with rx_dv_o=1, rx_er_o=1, rxd_o=0 and ends the frame.
- R10: A loss of lock inside a frame gives an abort strobe with rx_dv_o=1, rx_er_o=1, rxd_o=0 in the next cycle. rx_dv_o is 0 one cycle after that. Alignment is dropped until the next /J/K/.
- R11: In fiber mode (fiber_i=1) NRZ bits go to the group decoder unscrambled, lock_o stays 0 and no idle preamble is needed.
- R12: Cycles with bit_en_i low do not advance the decoder. No nib_en_o pulse comes two cycles after such a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | Qualifies nrzi_i as a new line bit |
| nrzi_i | input | 1 | Sampled NRZI line level |
| fiber_i | input | 1 | 1: fiber mode, descrambler bypassed |
| nib_en_o | output | 1 | One-cycle strobe per decoded group or abort |
| rx_dv_o | output | 1 | Receive data valid |
| rx_er_o | output | 1 | Receive error for the current nibble |
| rxd_o | output | 4 | Decoded nibble |
| lock_o | output | 1 | Copper descrambler synchronized |

## Verification
The hardest case to reach from the ports is a loss of lock in the middle of a frame. The descrambler must first be locked, a frame must be open, and only then may the plaintext show a zero run that legal code groups can never produce. The bench scrambles its own plaintext with an independent keystream. After the start pair and one data group it inserts a run of plaintext zeros, then checks for the abort strobe and the cleared lock. It then checks that a long idle run relocks the descrambler and that a later frame decodes cleanly.

// File: rtl/fe_rx_pkg.sv
package fe_rx_pkg;
  localparam int SYM_W = 5;
  localparam int NIB_W = 4;
  localparam int WIN_W = 2 * SYM_W;
  localparam logic [WIN_W-1:0] SSD_PAT  = 10'b11000_10001;
  localparam logic [SYM_W-1:0] GRP_IDL  = 5'b11111;
  localparam logic [SYM_W-1:0] GRP_TRM  = 5'b01101;

  typedef enum logic [1:0] {GK_DATA, GK_IDLE, GK_END, GK_BAD} grp_kind_e;

  typedef struct packed {
    grp_kind_e        kind;
    logic [NIB_W-1:0] nib;
  } grp_dec_t;

  function automatic grp_dec_t decode_5b(input logic [SYM_W-1:0] g);
    grp_dec_t r;
    r.kind = GK_DATA;
    r.nib  = '0;
    case (g)
      5'b11110: r.nib = 4'h0;
      5'b01001: r.nib = 4'h1;
      5'b10100: r.nib = 4'h2;
      5'b10101: r.nib = 4'h3;
      5'b01010: r.nib = 4'h4;
      5'b01011: r.nib = 4'h5;
      5'b01110: r.nib = 4'h6;
      5'b01111: r.nib = 4'h7;
      5'b10010: r.nib = 4'h8;
      5'b10011: r.nib = 4'h9;
      5'b10110: r.nib = 4'hA;
      5'b10111: r.nib = 4'hB;
      5'b11010: r.nib = 4'hC;
      5'b11011: r.nib = 4'hD;
      5'b11100: r.nib = 4'hE;
      5'b11101: r.nib = 4'hF;
      GRP_IDL:  r.kind = GK_IDLE;
      GRP_TRM:  r.kind = GK_END;
      default:  r.kind = GK_BAD;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/fe_rx_nrzi.sv
module fe_rx_nrzi (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_en_i,
  input  logic line_i,
  output logic nrz_o
);
  logic last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       last_q <= 1'b0;
    else if (bit_en_i) last_q <= line_i;
  end

  assign nrz_o = line_i ^ last_q;
endmodule

// File: rtl/fe_rx_descrambler.sv
module fe_rx_descrambler #(
  parameter int LOCK_RUN   = 32,
  parameter int ZERO_LIMIT = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fiber_i,
  input  logic bit_en_i,
  input  logic bit_i,
  output logic out_o,
  output logic out_en_o,
  output logic lock_o,
  output logic drop_o
);
  localparam int LFSR_W = 11;
  localparam int TAP_LO = 8;
  localparam int LC_W   = $clog2(LOCK_RUN + 1);
  localparam int ZC_W   = $clog2(ZERO_LIMIT + 1);

  logic [LFSR_W-1:0] st_q;
  logic [LC_W-1:0]   lcnt_q;
  logic [ZC_W-1:0]   zcnt_q;
  logic              key, plain;

  assign key   = st_q[LFSR_W-1] ^ st_q[TAP_LO];
  assign plain = bit_i ^ key;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= '0;
      lcnt_q   <= '0;
      zcnt_q   <= '0;
      out_o    <= 1'b0;
      out_en_o <= 1'b0;
      lock_o   <= 1'b0;
      drop_o   <= 1'b0;
    end else begin
      out_en_o <= 1'b0;
      drop_o   <= 1'b0;
      if (fiber_i) begin
        out_o    <= bit_i;
        out_en_o <= bit_en_i;
        lock_o   <= 1'b0;
        lcnt_q   <= '0;
        zcnt_q   <= '0;
      end else if (bit_en_i) begin
        if (!lock_o) begin
          // idle plaintext is all ones, so the line bit inverted is keystream
          st_q <= {st_q[LFSR_W-2:0], ~bit_i};
          if (plain) begin
            if (lcnt_q == LC_W'(LOCK_RUN - 1)) begin
              lock_o <= 1'b1;
              lcnt_q <= '0;
              zcnt_q <= '0;
            end else begin
              lcnt_q <= lcnt_q + 1'b1;
            end
          end else begin
            lcnt_q <= '0;
          end
        end else begin
          st_q <= {st_q[LFSR_W-2:0], key};
          if (!plain && zcnt_q == ZC_W'(ZERO_LIMIT - 1)) begin
            lock_o <= 1'b0;
            drop_o <= 1'b1;
            zcnt_q <= '0;
          end else begin
            out_o    <= plain;
            out_en_o <= 1'b1;
            zcnt_q   <= plain ? '0 : zcnt_q + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/fe_rx_framer.sv
module fe_rx_framer
  import fe_rx_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_en_i,
  input  logic             bit_i,
  input  logic             drop_i,
  output logic             in_frame_o,
  output logic             nib_en_o,
  output logic             rx_dv_o,
  output logic             rx_er_o,
  output logic [NIB_W-1:0] rxd_o
);
  localparam int CNT_W = $clog2(SYM_W);

  logic [WIN_W-2:0] win_q;
  logic [WIN_W-1:0] win_n;
  logic [CNT_W-1:0] cnt_q;
  logic             aligned_q, abort_q;
  grp_dec_t         dec;

  assign win_n = {win_q, bit_i};
  assign dec   = decode_5b(win_n[SYM_W-1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q      <= '0;
      cnt_q      <= '0;
      aligned_q  <= 1'b0;
      abort_q    <= 1'b0;
      in_frame_o <= 1'b0;
      nib_en_o   <= 1'b0;
      rx_dv_o    <= 1'b0;
      rx_er_o    <= 1'b0;
      rxd_o      <= '0;
    end else begin
      nib_en_o <= 1'b0;
      abort_q  <= 1'b0;
      if (abort_q) begin
        rx_dv_o <= 1'b0;
        rx_er_o <= 1'b0;
      end
      if (drop_i) begin
        aligned_q  <= 1'b0;
        in_frame_o <= 1'b0;
        cnt_q      <= '0;
        if (in_frame_o) begin
          nib_en_o <= 1'b1;
          rx_dv_o  <= 1'b1;
          rx_er_o  <= 1'b1;
          rxd_o    <= '0;
          abort_q  <= 1'b1;
        end
      end else if (bit_en_i) begin
        win_q <= win_n[WIN_W-2:0];
        if (!in_frame_o && win_n == SSD_PAT) begin
          in_frame_o <= 1'b1;
          aligned_q  <= 1'b1;
          cnt_q      <= '0;
        end else if (aligned_q) begin
          if (cnt_q == CNT_W'(SYM_W - 1)) begin
            cnt_q    <= '0;
            nib_en_o <= 1'b1;
            rxd_o    <= '0;
            rx_dv_o  <= 1'b0;
            rx_er_o  <= 1'b0;
            if (in_frame_o) begin
              case (dec.kind)
                GK_DATA: begin
                  rx_dv_o <= 1'b1;
                  rxd_o   <= dec.nib;
                end
                GK_END: in_frame_o <= 1'b0;
                GK_IDLE: begin
                  rx_dv_o    <= 1'b1;
                  rx_er_o    <= 1'b1;
                  in_frame_o <= 1'b0;
                end
                default: begin
                  rx_dv_o <= 1'b1;
                  rx_er_o <= 1'b1;
                end
              endcase
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/fe_pcs_rx.sv
module fe_pcs_rx #(
  parameter int LOCK_RUN   = 32,
  parameter int ZERO_LIMIT = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bit_en_i,
  input  logic       nrzi_i,
  input  logic       fiber_i,
  output logic       nib_en_o,
  output logic       rx_dv_o,
  output logic       rx_er_o,
  output logic [3:0] rxd_o,
  output logic       lock_o
);
  logic nrz, pt_bit, pt_en, lock_drop, in_frame;

  fe_rx_nrzi u_nrzi (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bit_en_i (bit_en_i),
    .line_i   (nrzi_i),
    .nrz_o    (nrz)
  );

  fe_rx_descrambler #(
    .LOCK_RUN   (LOCK_RUN),
    .ZERO_LIMIT (ZERO_LIMIT)
  ) u_dscr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fiber_i  (fiber_i),
    .bit_en_i (bit_en_i),
    .bit_i    (nrz),
    .out_o    (pt_bit),
    .out_en_o (pt_en),
    .lock_o   (lock_o),
    .drop_o   (lock_drop)
  );

  fe_rx_framer u_framer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bit_en_i   (pt_en),
    .bit_i      (pt_bit),
    .drop_i     (lock_drop),
    .in_frame_o (in_frame),
    .nib_en_o   (nib_en_o),
    .rx_dv_o    (rx_dv_o),
    .rx_er_o    (rx_er_o),
    .rxd_o      (rxd_o)
  );
endmodule

// File: rtl/fe_pcs_rx_chk.sv
module fe_pcs_rx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic bit_en_i,
  input logic fiber_i,
  input logic nib_en_o,
  input logic rx_dv_o,
  input logic rx_er_o,
  input logic lock_o,
  input logic lock_drop,
  input logic in_frame
);
  assert_er_needs_dv_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nib_en_o && rx_er_o) |-> rx_dv_o);

  assert_abort_strobe_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_drop && in_frame) |=> (nib_en_o && rx_dv_o && rx_er_o));

  assert_abort_dv_low_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_drop && in_frame) |=> ##1 !rx_dv_o);

  assert_lock_fall_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lock_o) |-> (lock_drop || $past(fiber_i)));

  assert_fiber_nolock_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fiber_i && $past(fiber_i)) |-> !lock_o);

  assert_gap_no_strobe_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_en_i |=> ##1 !nib_en_o);
endmodule

bind fe_pcs_rx fe_pcs_rx_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .bit_en_i  (bit_en_i),
  .fiber_i   (fiber_i),
  .nib_en_o  (nib_en_o),
  .rx_dv_o   (rx_dv_o),
  .rx_er_o   (rx_er_o),
  .lock_o    (lock_o),
  .lock_drop (lock_drop),
  .in_frame  (in_frame)
);

// File: tb/fe_pcs_rx_tb.sv
module fe_pcs_rx_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       bit_en_i = 1'b0;
  logic       nrzi_i = 1'b0;
  logic       fiber_i = 1'b0;
  logic       nib_en_o, rx_dv_o, rx_er_o, lock_o;
  logic [3:0] rxd_o;

  int n_chk = 0;
  int n_bad = 0;

  logic [10:0] sc;
  logic        line;
  logic        gap = 1'b0;
  logic [4:0]  ev_q[$];
  logic [4:0]  exp_q[$];
  logic [3:0]  nib_q[$];

  always #2 clk_i = ~clk_i;

  fe_pcs_rx u_dut (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bit_en_i (bit_en_i),
    .nrzi_i   (nrzi_i),
    .fiber_i  (fiber_i),
    .nib_en_o (nib_en_o),
    .rx_dv_o  (rx_dv_o),
    .rx_er_o  (rx_er_o),
    .rxd_o    (rxd_o),
    .lock_o   (lock_o)
  );

  always @(negedge clk_i)
    if (rst_ni && nib_en_o && rx_dv_o) ev_q.push_back({rx_er_o, rxd_o});

  function automatic logic [4:0] enc5(input logic [3:0] n);
    case (n)
      4'h0: return 5'b11110;  4'h1: return 5'b01001;
      4'h2: return 5'b10100;  4'h3: return 5'b10101;
      4'h4: return 5'b01010;  4'h5: return 5'b01011;
      4'h6: return 5'b01110;  4'h7: return 5'b01111;
      4'h8: return 5'b10010;  4'h9: return 5'b10011;
      4'hA: return 5'b10110;  4'hB: return 5'b10111;
      4'hC: return 5'b11010;  4'hD: return 5'b11011;
      4'hE: return 5'b11100;  default: return 5'b11101;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tx_bit(input logic p);
    logic k, c;
    k  = sc[10] ^ sc[8];
    sc = {sc[9:0], k};
    c  = fiber_i ? p : (p ^ k);
    line = line ^ c;
    @(negedge clk_i);
    nrzi_i   = line;
    bit_en_i = 1'b1;
    if (gap) begin
      @(negedge clk_i);
      bit_en_i = 1'b0;
    end
  endtask

  task automatic send_code(input logic [4:0] g);
    for (int i = 4; i >= 0; i--) tx_bit(g[i]);
  endtask

  task automatic send_idle(input int n);
    repeat (n) tx_bit(1'b1);
  endtask

  task automatic send_jk();
    send_code(5'b11000);
    send_code(5'b10001);
  endtask

  task automatic settle();
    @(negedge clk_i);
    bit_en_i = 1'b0;
    repeat (6) @(negedge clk_i);
  endtask

  task automatic send_frame();
    send_idle(12);
    send_jk();
    foreach (nib_q[i]) send_code(enc5(nib_q[i]));
    send_code(5'b01101);
    send_code(5'b00111);
    send_idle(20);
    settle();
  endtask

  task automatic cmp_events(input string req);
    chk(ev_q.size() == exp_q.size(), req, "event count", ev_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < ev_q.size(); i++)
      chk(ev_q[i] == exp_q[i], req, $sformatf("event %0d {er,rxd}", i), ev_q[i], exp_q[i]);
    ev_q.delete();
    exp_q.delete();
  endtask

  task automatic data_exp();
    foreach (nib_q[i]) exp_q.push_back({1'b0, nib_q[i]});
  endtask

  task automatic do_reset(input logic fib);
    rst_ni   = 1'b0;
    bit_en_i = 1'b0;
    nrzi_i   = 1'b0;
    fiber_i  = fib;
    gap      = 1'b0;
    line     = 1'b0;
    sc       = 11'h5A3;
    repeat (4) @(negedge clk_i);
    chk(!nib_en_o && !rx_dv_o && !rx_er_o && !lock_o, "R1", "outputs in reset",
        {nib_en_o, rx_dv_o, rx_er_o, lock_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    ev_q.delete();
    exp_q.delete();
  endtask

  task automatic t_reset();
    do_reset(1'b0);
    repeat (3) @(negedge clk_i);
    chk(!nib_en_o && !rx_dv_o && !rx_er_o && !lock_o, "R1", "outputs after reset",
        {nib_en_o, rx_dv_o, rx_er_o, lock_o}, 0);
  endtask

  task automatic t_lock();
    send_idle(20);
    settle();
    chk(lock_o == 1'b0, "R3", "lock after 20 idle bits", lock_o, 0);
    send_idle(60);
    settle();
    chk(lock_o == 1'b1, "R3", "lock after 80 idle bits", lock_o, 1);
  endtask

  task automatic t_frame();
    nib_q = '{4'h5, 4'hD, 4'h0, 4'hA, 4'h3};
    data_exp();
    send_frame();
    cmp_events("R6 R7 R2 copper frame");
    chk(rx_dv_o == 1'b0, "R7", "dv after end of frame", rx_dv_o, 0);
  endtask

  task automatic t_all_nibbles();
    nib_q.delete();
    for (int i = 0; i < 16; i++) nib_q.push_back(4'(i));
    data_exp();
    send_frame();
    cmp_events("R6 all nibble codes");
  endtask

  task automatic t_no_jk();
    send_idle(12);
    repeat (6) send_code(enc5(4'h7));
    send_idle(20);
    settle();
    cmp_events("R5 no start pair");
  endtask

  task automatic t_bad_code();
    send_idle(12);
    send_jk();
    send_code(enc5(4'h6));
    send_code(5'b11001);
    send_code(enc5(4'hB));
    send_code(5'b01101);
    send_code(5'b00111);
    send_idle(20);
    settle();
    exp_q = '{{1'b0, 4'h6}, {1'b1, 4'h0}, {1'b0, 4'hB}};
    cmp_events("R8 invalid group");
  endtask

  task automatic t_early_idle();
    send_idle(12);
    send_jk();
    send_code(enc5(4'h3));
    send_code(enc5(4'hC));
    send_code(5'b11111);
    send_idle(5);
    send_code(enc5(4'h9));
    send_idle(20);
    settle();
    exp_q = '{{1'b0, 4'h3}, {1'b0, 4'hC}, {1'b1, 4'h0}};
    cmp_events("R9 premature idle");
  endtask

  task automatic t_lock_loss();
    send_idle(12);
    send_jk();
    send_code(enc5(4'h0));
    repeat (8) tx_bit(1'b0);
    settle();
    exp_q = '{{1'b0, 4'h0}, {1'b1, 4'h0}};
    cmp_events("R10 abort on lock loss");
    chk(lock_o == 1'b0, "R4", "lock after zero run", lock_o, 0);
    chk(rx_dv_o == 1'b0, "R10", "dv after abort", rx_dv_o, 0);
    send_idle(80);
    settle();
    chk(lock_o == 1'b1, "R3", "relock after idles", lock_o, 1);
    nib_q = '{4'h9, 4'h1};
    data_exp();
    send_frame();
    cmp_events("R10 frame after relock");
  endtask

  task automatic t_gap();
    gap = 1'b1;
    nib_q = '{4'hE, 4'h2, 4'h7};
    data_exp();
    send_frame();
    gap = 1'b0;
    cmp_events("R12 sparse bit enable");
  endtask

  task automatic t_fiber();
    do_reset(1'b1);
    nib_q = '{4'h4, 4'hF, 4'h8};
    data_exp();
    send_frame();
    cmp_events("R11 R2 fiber frame");
    chk(lock_o == 1'b0, "R11", "lock in fiber mode", lock_o, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_lock();
    t_frame();
    t_all_nibbles();
    t_no_jk();
    t_bad_code();
    t_early_idle();
    t_gap();
    t_lock_loss();
    t_fiber();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule